// File: doc/BRIEF.md
# Serial Command Port for a Duplex Display Controller

This block is the host-facing command port of a display controller. A host frames each transfer with a chip-select line. While chip select is high, one data bit is taken on every rising edge of a serial clock. When chip select falls, the block reads a 4-bit command code from the word it has collected and acts on it. Depending on the code it can capture a new display image, switch between analog and digital dimming, load an 11-bit digital dimming value, prepare a key-matrix readout, or send a pulse that stops key scanning. After a transfer that prepares a readout, the next chip-select window turns the shared data pin into an output and shifts out a 30-bit key image. A cascade output gives the serial input delayed by 64 shifts, so several parts can be chained on one serial line.

The serial clock, chip select and data pins are asynchronous to the system clock. They are synchronized into the system clock domain and their edges are detected there. The incoming bit enters at the top of a 64-bit register and moves down. When a frame ends, the last four bits shifted in hold the command code, and the last bit is the code's most significant bit. A 16-bit dimming frame is sent as one filler bit, then 11 dimming bits (least significant first), then the code bits starting with the least significant.

Top module: `cmd_port`

## Requirements
- R1: Bits are shifted only on a rising serial-clock edge while chip select is high. Clock edges while chip select is low leave the collected word unchanged, so an empty chip-select window that follows them latches the previous word again.
- R2: When chip select falls and the code in word bits [63:60] is 0000, 0010, 0100 or 0110, the display output takes word bits [59:0]. With any other code it holds its value, and it changes at no other time.
- R3: Codes 0011 and 0010 select analog dimming (`dim_digital_o` = 0). Codes 0101, 0100 and 0001 select digital dimming (`dim_digital_o` = 1). All other codes leave the selection unchanged.
- R4: Code 0001 loads word bits [59:49] into `dim_val_o`, with bit 49 as the least significant bit. No other code changes `dim_val_o`.
- R5: Codes 1010 through 1111 have no effect on any output.
- R6: Codes 0111, 0110 and 1000 arm a readout. In the next chip-select window the data pin output is enabled and presents key bit 0 first; each rising serial-clock edge advances to the next bit. No bits are shifted into the word during that window. When that window's chip select falls, the output enable drops, no code is acted on, and the next frame is treated as normal input.
- R7: Codes 1000 and 1001 produce a key-scan stop pulse that lasts exactly one system clock cycle.
- R8: The cascade output gives the bit that was shifted in 64 shifts earlier. It updates on each shift.
- R9: After reset the word, the display output, `dim_val_o`, the cascade output and the stop pulse are all zero. Analog dimming is selected and no readout is armed.
- R10: A frame shorter than 64 bits is still acted on when chip select falls. Its code comes from the last four bits shifted in, so a 4-bit frame is a complete command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, transfer window while high |
| sclk_i | input | 1 | Serial clock, sampled on rising edge |
| sdio_i | input | 1 | Data pin, input side |
| key_i | input | 30 | Key image to present during a readout |
| sdio_o | output | 1 | Data pin, output value |
| sdio_oe_o | output | 1 | Data pin output enable |
| casc_o | output | 1 | Serial input delayed by 64 shifts |
| disp_o | output | 60 | Latched display image |
| dim_digital_o | output | 1 | 1 = digital dimming, 0 = analog dimming |
| dim_val_o | output | 11 | Digital dimming value |
| scan_stop_o | output | 1 | One-cycle key-scan stop pulse |

## Verification
The checks assume that each level of chip select and of the serial clock lasts longer than the synchronizer depth plus one system cycle. They also assume that the data bit is stable before each rising serial-clock edge is synchronized, and that chip select rises before the first serial-clock edge of a window and falls only after the last. The stimulus holds every serial-clock phase for four system cycles. It leaves a margin of at least six cycles around each chip-select edge, and it changes data only while the serial clock is low. The key image is kept constant from the start of a readout window until that window ends.

// File: rtl/cmd_port_pkg.sv
package cmd_port_pkg;

  localparam int MODE_W = 4;

  typedef struct packed {
    logic disp_ld;
    logic sel_analog;
    logic sel_digital;
    logic dim_ld;
    logic scan_rd;
    logic scan_stop;
  } cmd_act_t;

  function automatic cmd_act_t decode_mode(input logic [MODE_W-1:0] m);
    cmd_act_t a;
    a = '0;
    case (m)
      4'b0000: a.disp_ld = 1'b1;
      4'b0011: a.sel_analog = 1'b1;
      4'b0101: a.sel_digital = 1'b1;
      4'b0001: begin a.sel_digital = 1'b1; a.dim_ld = 1'b1; end
      4'b0111: a.scan_rd = 1'b1;
      4'b0110: begin a.disp_ld = 1'b1; a.scan_rd = 1'b1; end
      4'b0010: begin a.disp_ld = 1'b1; a.sel_analog = 1'b1; end
      4'b0100: begin a.disp_ld = 1'b1; a.sel_digital = 1'b1; end
      4'b1000: begin a.scan_rd = 1'b1; a.scan_stop = 1'b1; end
      4'b1001: a.scan_stop = 1'b1;
      default: a = '0; // test codes: inert
    endcase
    return a;
  endfunction

endpackage

// File: rtl/cmd_sync.sv
module cmd_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i[g];
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/cmd_shift.sv
module cmd_shift #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] sreg_o,
  output logic         casc_o
);

  logic [W-1:0] sreg_q;
  logic         casc_q;

  // new bit enters at the top; bit 0 leaves into the cascade flop
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sreg_q <= '0;
      casc_q <= 1'b0;
    end else if (shift_en_i) begin
      sreg_q <= {bit_i, sreg_q[W-1:1]};
      casc_q <= sreg_q[0];
    end

  assign sreg_o = sreg_q;
  assign casc_o = casc_q;

endmodule

// File: rtl/cmd_keyout.sv
module cmd_keyout #(
  parameter int KEY_W = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [KEY_W-1:0] image_i,
  output logic             bit_o
);

  logic [KEY_W-1:0] kreg_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     kreg_q <= '0;
    else if (load_i) kreg_q <= image_i;
    else if (adv_i)  kreg_q <= {1'b0, kreg_q[KEY_W-1:1]};

  assign bit_o = kreg_q[0];

endmodule

// File: rtl/cmd_port.sv
module cmd_port
  import cmd_port_pkg::*;
#(
  parameter int SHIFT_W     = 64,
  parameter int DISP_W      = 60,
  parameter int DIM_W       = 11,
  parameter int KEY_W       = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              sdio_o,
  output logic              sdio_oe_o,
  output logic              casc_o,
  output logic [DISP_W-1:0] disp_o,
  output logic              dim_digital_o,
  output logic [DIM_W-1:0]  dim_val_o,
  output logic              scan_stop_o
);

  localparam int MODE_LSB = SHIFT_W - MODE_W;
  localparam int DIM_LSB  = MODE_LSB - DIM_W;

  logic [2:0]         pin_q;
  logic               cs_q, sclk_q, sdi_q;
  logic               cs_p, sclk_p;
  logic               cs_rise, cs_fall, sclk_rise;
  logic               rd_armed, rd_active;
  logic               shift_en, cmd_go;
  logic [SHIFT_W-1:0] sreg;
  cmd_act_t           act;

  cmd_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdio_i, sclk_i, cs_i}),
    .q_o   (pin_q)
  );

  assign cs_q   = pin_q[0];
  assign sclk_q = pin_q[1];
  assign sdi_q  = pin_q[2];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cs_p   <= 1'b0;
      sclk_p <= 1'b0;
    end else begin
      cs_p   <= cs_q;
      sclk_p <= sclk_q;
    end

  assign cs_rise   = cs_q & ~cs_p;
  assign cs_fall   = ~cs_q & cs_p;
  assign sclk_rise = sclk_q & ~sclk_p & cs_q;

  assign shift_en = sclk_rise & ~rd_active;
  assign cmd_go   = cs_fall & ~rd_active;

  cmd_shift #(.W(SHIFT_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .bit_i     (sdi_q),
    .sreg_o    (sreg),
    .casc_o    (casc_o)
  );

  cmd_keyout #(.KEY_W(KEY_W)) u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cs_rise & rd_armed),
    .adv_i  (sclk_rise & rd_active),
    .image_i(key_i),
    .bit_o  (sdio_o)
  );

  assign act = decode_mode(sreg[MODE_LSB +: MODE_W]);

  // readout sequencing: arm on command, run for one whole CS window
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rd_armed  <= 1'b0;
      rd_active <= 1'b0;
    end else if (cs_rise && rd_armed) begin
      rd_armed  <= 1'b0;
      rd_active <= 1'b1;
    end else if (cs_fall && rd_active) begin
      rd_active <= 1'b0;
    end else if (cmd_go && act.scan_rd) begin
      rd_armed  <= 1'b1;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      disp_o        <= '0;
      dim_digital_o <= 1'b0;
      dim_val_o     <= '0;
      scan_stop_o   <= 1'b0;
    end else begin
      scan_stop_o <= cmd_go & act.scan_stop;
      if (cmd_go) begin
        if (act.disp_ld)     disp_o        <= sreg[DISP_W-1:0];
        if (act.sel_analog)  dim_digital_o <= 1'b0;
        if (act.sel_digital) dim_digital_o <= 1'b1;
        if (act.dim_ld)      dim_val_o     <= sreg[DIM_LSB +: DIM_W];
      end
    end

  assign sdio_oe_o = rd_active & cs_q;

endmodule

// File: rtl/cmd_port_chk.sv
module cmd_port_chk #(
  parameter int SHIFT_W     = 64,
  parameter int DISP_W      = 60,
  parameter int DIM_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cs_i,
  input logic               cs_q,
  input logic               cs_fall,
  input logic [SHIFT_W-1:0] sreg,
  input logic [DISP_W-1:0]  disp_o,
  input logic [DIM_W-1:0]   dim_val_o,
  input logic               scan_stop_o,
  input logic               sdio_oe_o
);

  p_shift_gated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_q |=> $stable(sreg));

  p_disp_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall |=> $stable(disp_o));

  p_dim_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall |=> $stable(dim_val_o));

  p_stop_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_stop_o |=> !scan_stop_o);

  p_stop_at_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scan_stop_o) |-> $past(cs_fall));

  p_oe_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> $past(cs_i, SYNC_STAGES));

endmodule

bind cmd_port cmd_port_chk #(
  .SHIFT_W(SHIFT_W), .DISP_W(DISP_W), .DIM_W(DIM_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_i       (cs_i),
  .cs_q       (cs_q),
  .cs_fall    (cs_fall),
  .sreg       (sreg),
  .disp_o     (disp_o),
  .dim_val_o  (dim_val_o),
  .scan_stop_o(scan_stop_o),
  .sdio_oe_o  (sdio_oe_o)
);

// File: tb/sim_cmd_port.sv
`timescale 1ns/1ps
module sim_cmd_port;

  logic        clk = 1'b0;
  logic        rst_ni, cs_i, sclk_i, sdio_i;
  logic [29:0] key_i;
  logic        sdio_o, sdio_oe_o, casc_o, dim_digital_o, scan_stop_o;
  logic [59:0] disp_o;
  logic [10:0] dim_val_o;

  int checks = 0;
  int fails = 0;
  int stop_cnt = 0;

  always #2.5 clk = ~clk;

  cmd_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
    .key_i(key_i), .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .casc_o(casc_o),
    .disp_o(disp_o), .dim_digital_o(dim_digital_o), .dim_val_o(dim_val_o),
    .scan_stop_o(scan_stop_o)
  );

  always @(posedge clk) if (rst_ni && scan_stop_o) stop_cnt++;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    sdio_i = b; idle(4);
    sclk_i = 1'b1; idle(4);
    sclk_i = 1'b0; idle(4);
  endtask

  task automatic frame(input logic [63:0] v, input int n);
    cs_i = 1'b1; idle(6);
    for (int i = 0; i < n; i++) clk_bit(v[i]);
    idle(2); cs_i = 1'b0; idle(8);
  endtask

  // follow-up window: readout if armed, else a 4-bit inert code 1111
  task automatic window(input logic exp_rd, input logic [29:0] img);
    key_i = img;
    cs_i = 1'b1; idle(6);
    chk("R6 oe in window", 64'(sdio_oe_o), 64'(exp_rd));
    for (int i = 0; i < (exp_rd ? 30 : 4); i++) begin
      if (exp_rd) chk("R6 key bit", 64'(sdio_o), 64'(img[i]));
      clk_bit(1'b1);
    end
    idle(2); cs_i = 1'b0; idle(8);
    chk("R6 oe after window", 64'(sdio_oe_o), 64'd0);
  endtask

  function automatic logic [63:0] dim_frame(input logic [3:0] m, input logic [10:0] d);
    return 64'({m, d, 1'b0});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [59:0] pa, pb;
    logic [63:0] fa, fb;
    rst_ni = 1'b0; cs_i = 1'b0; sclk_i = 1'b0; sdio_i = 1'b0; key_i = '0;
    idle(5); rst_ni = 1'b1; idle(3);

    // R9 reset state
    chk("R9 disp", 64'(disp_o), 64'd0);
    chk("R9 dim sel", 64'(dim_digital_o), 64'd0);
    chk("R9 dim val", 64'(dim_val_o), 64'd0);
    chk("R9 oe", 64'(sdio_oe_o), 64'd0);
    chk("R9 casc", 64'(casc_o), 64'd0);
    chk("R9 stop", 64'(scan_stop_o), 64'd0);

    // R2 display load, then R1 clocks outside CS
    pa = 60'hA5C_3F01_9E72_4B6D;
    frame({4'b0000, pa}, 64);
    chk("R2 display load", 64'(disp_o), 64'(pa));
    for (int i = 0; i < 64; i++) clk_bit(1'b1);
    frame(64'd0, 0);
    chk("R1 no shift with CS low", 64'(disp_o), 64'(pa));

    // R10 short frames
    frame(64'b0101, 4);
    chk("R10 4-bit digital select", 64'(dim_digital_o), 64'd1);
    frame(64'b0011, 4);
    chk("R10 4-bit analog select", 64'(dim_digital_o), 64'd0);

    // R4 dimming data boundaries
    frame(dim_frame(4'b0001, 11'h7FF), 16);
    chk("R4 dim all ones", 64'(dim_val_o), 64'h7FF);
    chk("R4 dim selects digital", 64'(dim_digital_o), 64'd1);
    frame(dim_frame(4'b0001, 11'h001), 16);
    chk("R4 dim lsb", 64'(dim_val_o), 64'h001);
    frame(dim_frame(4'b0001, 11'h400), 16);
    chk("R4 dim msb", 64'(dim_val_o), 64'h400);
    frame(dim_frame(4'b0001, 11'h000), 16);
    chk("R4 dim zero", 64'(dim_val_o), 64'h000);

    // R8 cascade delay of 64 shifts
    pb = 60'h123_4567_89AB_CDEF;
    fa = {4'b0000, pb};
    frame(fa, 64);
    fb = {4'hF, 60'h0F0_F0F0_F0F0_F0F0};
    cs_i = 1'b1; idle(6);
    for (int j = 0; j < 64; j++) begin
      clk_bit(fb[j]);
      chk("R8 cascade", 64'(casc_o), 64'(fa[j]));
    end
    idle(2); cs_i = 1'b0; idle(8);
    chk("R5 inert code keeps display", 64'(disp_o), 64'(pb));

    // R3 R5 R6 R7 sweep over every code
    for (int c = 0; c < 16; c++) begin
      logic [3:0]  m;
      logic [59:0] p0, p1;
      logic [10:0] d0;
      logic        e_disp, e_an, e_dg, e_dim, e_rd, e_stop, e_sel;
      int          s0;
      m  = 4'(c);
      p0 = 60'h5A5_A5A5_A5A5_A5A5 ^ {15{~m}};
      p1 = 60'hC3C_3C3C_3C3C_3C3C ^ {15{m}};
      d0 = 11'h2AA ^ {m, 7'd0};
      frame({4'b0000, p0}, 64);
      chk("R6 display input resumes", 64'(disp_o), 64'(p0));
      frame(dim_frame(4'b0001, d0), 16);
      e_disp = (m inside {4'b0000, 4'b0010, 4'b0100, 4'b0110});
      e_an   = (m inside {4'b0011, 4'b0010});
      e_dg   = (m inside {4'b0101, 4'b0100, 4'b0001});
      e_dim  = (m == 4'b0001);
      e_rd   = (m inside {4'b0111, 4'b0110, 4'b1000});
      e_stop = (m inside {4'b1000, 4'b1001});
      e_sel  = e_an ? 1'b0 : 1'b1;
      s0 = stop_cnt;
      frame({m, p1}, 64);
      chk(m >= 4'hA ? "R5 display" : "R2 display", 64'(disp_o), e_disp ? 64'(p1) : 64'(p0));
      chk(m >= 4'hA ? "R5 dim select" : "R3 dim select", 64'(dim_digital_o), 64'(e_sel));
      chk(m >= 4'hA ? "R5 dim value" : "R4 dim value", 64'(dim_val_o),
          e_dim ? 64'(p1[59:49]) : 64'(d0));
      chk("R7 stop pulses", 64'(stop_cnt - s0), e_stop ? 64'd1 : 64'd0);
      window(e_rd, 30'h1A2B_3C4D ^ {26'd0, m});
      chk(m >= 4'hA ? "R5 display after window" : "R6 display after window",
          64'(disp_o), e_disp ? 64'(p1) : 64'(p0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule